// File: doc/BRIEF.md
# DMA Minor-Loop Channel Engine

This block executes the minor loop of one active DMA channel. After a start strobe it latches a descriptor and moves data in 4-byte beats. Each beat is a read from the source address followed by a write of that word to the destination address, both over a single-port memory port with request and acknowledge. Once the programmed byte count is used up, the channel retires. The retirement pulses `done_o`, optionally adds a signed minor-loop offset to either address, and then either goes idle or restarts at once when the channel links to itself in continuous mode.

Software can stop a running loop in two ways. A cancel strobe and an error-cancel strobe both stop the loop at the next read/write pair boundary, and the channel then retires as a normal completion. An error-cancel also raises the error flag and, when enabled, a one-cycle interrupt. Channel arbitration, major-loop counting and bus-error detection sit outside this block. The `link_req_o` pulse tells the surrounding arbiter that a self-linked channel needs to be scheduled again.

Top module: `dma_minor_loop_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `mem_req_o`, `done_o`, `error_o`, `irq_o` and `link_req_o` are all 0.
- R2: Each beat reads from the current source address (`mem_we_o`=0), then writes the word it read to the current destination address (`mem_we_o`=1). A request holds its address and direction until `mem_ack_i`. After each beat the source and destination addresses advance by their own signed 16-bit increments.
- R3: A minor loop with effective byte count N performs ceil(N/4) beats, and at least one beat when N is 0. `done_o` is high for exactly one cycle, in the cycle after the acknowledge of the final write.
- R4: When mapping is on (`map_en_i`=1) and at least one offset enable is set, only bits [9:0] of `nbytes_i` count. In every other case all 32 bits count.
- R5: At retirement, the sign-extended 20-bit `loop_off_i` is added after the final increment. It goes to the source address when `map_en_i` and `src_off_en_i` are both 1, and to the destination address when `map_en_i` and `dst_off_en_i` are both 1. The resulting addresses appear on `src_addr_o`/`dst_addr_o` in the same cycle as `done_o`.
- R6: A `cancel_i` pulse during a loop lets the read/write pair in progress finish, including its write, then retires the channel with offsets applied, `done_o` and `error_o`=0. The pending cancel clears itself, so it does not affect the next loop.
- R7: An `err_cancel_i` pulse stops and retires the loop the same way as a cancel. It also sets `error_o`, which holds until the next accepted start, and pulses `irq_o` together with `done_o` when `err_irq_en_i` was 1 at start.
- R8: If `cancel_i` and `err_cancel_i` arrive in the same cycle, the error-cancel behaviour of R7 applies.
- R9: `cancel_i` and `err_cancel_i` pulses while the engine is idle are discarded and do not shorten a loop started later.
- R10: When `cont_link_i`=1 at retirement and the descriptor's `self_link_i` was 1, `busy_o` stays 1 and the next minor loop starts in the following cycle. It first reads from the offset-adjusted source address and runs a full byte count again.
- R11: When a self-linked loop retires with `cont_link_i`=0, the engine goes idle and `link_req_o` pulses together with `done_o`.
- R12: A `start_i` pulse while the engine is busy is ignored. The running loop finishes with its original descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load descriptor and begin a minor loop (idle only) |
| src_addr_i | input | 32 | Initial source address |
| dst_addr_i | input | 32 | Initial destination address |
| nbytes_i | input | 32 | Minor-loop byte count |
| src_inc_i | input | 16 | Signed source increment per beat |
| dst_inc_i | input | 16 | Signed destination increment per beat |
| loop_off_i | input | 20 | Signed minor-loop offset |
| map_en_i | input | 1 | Minor-loop mapping enable |
| src_off_en_i | input | 1 | Apply offset to source |
| dst_off_en_i | input | 1 | Apply offset to destination |
| self_link_i | input | 1 | Channel links to itself at minor-loop end |
| cont_link_i | input | 1 | Continuous link mode, sampled at retirement |
| err_irq_en_i | input | 1 | Error interrupt enable |
| cancel_i | input | 1 | Cancel strobe |
| err_cancel_i | input | 1 | Error-cancel strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Loop active |
| done_o | output | 1 | One-cycle retirement pulse |
| error_o | output | 1 | Error recorded by error-cancel |
| irq_o | output | 1 | One-cycle error interrupt |
| link_req_o | output | 1 | Self-link needs arbitration |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |

## Verification
The bench's memory responder raises `mem_ack_i` one cycle after each request, so every access spans two cycles and a beat spans four. `done_o`, `error_o`, `irq_o`, `link_req_o` and the updated addresses are all registered at the edge that takes the final write acknowledge, so they are due one cycle after that acknowledge. The bench waits for `done_o` and samples all of them on that same falling edge. It checks one falling edge later that `done_o` and `irq_o` have dropped. Cancel strobes are driven at a falling edge while a particular access of the first beat is pending. From that, the beat count expected at retirement is fixed, and it is compared with the bench's own log of writes.

// File: rtl/dmaml_pkg.sv
package dmaml_pkg;
    localparam int unsigned BEAT_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/dmaml_addr_step.sv
// Per-beat and retirement address arithmetic for one address stream.
module dmaml_addr_step #(
    parameter int AW = 32,
    parameter int IW = 16,
    parameter int OW = 20
) (
    input  logic [AW-1:0] base_i,
    input  logic [IW-1:0] inc_i,
    input  logic [OW-1:0] off_i,
    input  logic          off_en_i,
    output logic [AW-1:0] step_o,
    output logic [AW-1:0] retire_o
);
    logic [AW-1:0] inc_ext;
    logic [AW-1:0] off_ext;

    always_comb begin
        inc_ext  = {{(AW-IW){inc_i[IW-1]}}, inc_i};
        off_ext  = off_en_i ? {{(AW-OW){off_i[OW-1]}}, off_i} : '0;
        step_o   = base_i + inc_ext;
        retire_o = step_o + off_ext;
    end
endmodule

// File: rtl/dmaml_cancel_ctl.sv
// Holds cancel requests until the running read/write pair completes.
module dmaml_cancel_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic honor_i,
    input  logic cancel_i,
    input  logic err_cancel_i,
    output logic pend_o,
    output logic pend_err_o
);
    typedef struct packed {
        logic cxl;
        logic ecx;
    } cxl_t;

    cxl_t c_d, c_q;

    always_comb begin
        pend_err_o = c_q.ecx | (active_i & err_cancel_i);
        pend_o     = c_q.cxl | pend_err_o | (active_i & cancel_i);
        c_d        = c_q;
        if (!active_i || honor_i) begin
            c_d = '0;
        end else begin
            c_d.cxl = c_q.cxl | cancel_i;
            c_d.ecx = c_q.ecx | err_cancel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    p_ecx_from_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.ecx) |-> $past(err_cancel_i && active_i));

    p_idle_no_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!active_i) |-> !(c_q.cxl || c_q.ecx));
endmodule

// File: rtl/dma_minor_loop_engine.sv
module dma_minor_loop_engine #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int IW       = 16,
    parameter int OW       = 20,
    parameter int NBW      = 32,
    parameter int NB_MAP_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] src_addr_i,
    input  logic [AW-1:0] dst_addr_i,
    input  logic [NBW-1:0] nbytes_i,
    input  logic [IW-1:0] src_inc_i,
    input  logic [IW-1:0] dst_inc_i,
    input  logic [OW-1:0] loop_off_i,
    input  logic          map_en_i,
    input  logic          src_off_en_i,
    input  logic          dst_off_en_i,
    input  logic          self_link_i,
    input  logic          cont_link_i,
    input  logic          err_irq_en_i,
    input  logic          cancel_i,
    input  logic          err_cancel_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_ack_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o,
    output logic          irq_o,
    output logic          link_req_o,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o
);
    import dmaml_pkg::*;

    localparam logic [NBW-1:0] BEAT = NBW'(BEAT_BYTES);
    localparam int NSTREAM = 2;

    typedef struct packed {
        eng_state_e     st;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [NBW-1:0] rem;
        logic [NBW-1:0] nbytes;
        logic [DW-1:0]  data;
        logic [IW-1:0]  sinc;
        logic [IW-1:0]  dinc;
        logic [OW-1:0]  off;
        logic           soff;
        logic           doff;
        logic           self_link;
        logic           irq_en;
        logic           done;
        logic           err;
        logic           irq;
        logic           link_req;
    } eng_t;

    eng_t r_d, r_q;

    logic          active, honor, pend_any, pend_err;
    logic [AW-1:0] base  [NSTREAM];
    logic [IW-1:0] inc   [NSTREAM];
    logic          offen [NSTREAM];
    logic [AW-1:0] step  [NSTREAM];
    logic [AW-1:0] ret   [NSTREAM];

    assign base[0]  = r_q.src;
    assign base[1]  = r_q.dst;
    assign inc[0]   = r_q.sinc;
    assign inc[1]   = r_q.dinc;
    assign offen[0] = r_q.soff;
    assign offen[1] = r_q.doff;

    for (genvar g = 0; g < NSTREAM; g++) begin : g_stream
        dmaml_addr_step #(.AW(AW), .IW(IW), .OW(OW)) u_step (
            .base_i   (base[g]),
            .inc_i    (inc[g]),
            .off_i    (r_q.off),
            .off_en_i (offen[g]),
            .step_o   (step[g]),
            .retire_o (ret[g])
        );
    end

    assign active = (r_q.st != ST_IDLE);
    assign honor  = (r_q.st == ST_WRITE) && mem_ack_i;

    dmaml_cancel_ctl u_cancel (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (active),
        .honor_i      (honor),
        .cancel_i     (cancel_i),
        .err_cancel_i (err_cancel_i),
        .pend_o       (pend_any),
        .pend_err_o   (pend_err)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.irq      = 1'b0;
        r_d.link_req = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_READ;
                    r_d.src       = src_addr_i;
                    r_d.dst       = dst_addr_i;
                    r_d.nbytes    = (map_en_i && (src_off_en_i || dst_off_en_i))
                                    ? NBW'(nbytes_i[NB_MAP_W-1:0]) : nbytes_i;
                    r_d.rem       = r_d.nbytes;
                    r_d.sinc      = src_inc_i;
                    r_d.dinc      = dst_inc_i;
                    r_d.off       = loop_off_i;
                    r_d.soff      = map_en_i & src_off_en_i;
                    r_d.doff      = map_en_i & dst_off_en_i;
                    r_d.self_link = self_link_i;
                    r_d.irq_en    = err_irq_en_i;
                    r_d.err       = 1'b0;
                end
            end
            ST_READ: begin
                if (mem_ack_i) begin
                    r_d.data = mem_rdata_i;
                    r_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack_i) begin
                    if (r_q.rem <= BEAT || pend_any) begin
                        r_d.src  = ret[0];
                        r_d.dst  = ret[1];
                        r_d.done = 1'b1;
                        r_d.err  = r_q.err | pend_err;
                        r_d.irq  = pend_err & r_q.irq_en;
                        if (r_q.self_link && cont_link_i) begin
                            r_d.st  = ST_READ;
                            r_d.rem = r_q.nbytes;
                        end else begin
                            r_d.st       = ST_IDLE;
                            r_d.link_req = r_q.self_link;
                        end
                    end else begin
                        r_d.src = step[0];
                        r_d.dst = step[1];
                        r_d.rem = r_q.rem - BEAT;
                        r_d.st  = ST_READ;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o      = active;
    assign mem_req_o   = active;
    assign mem_we_o    = (r_q.st == ST_WRITE);
    assign mem_addr_o  = mem_we_o ? r_q.dst : r_q.src;
    assign mem_wdata_o = r_q.data;
    assign done_o      = r_q.done;
    assign error_o     = r_q.err;
    assign irq_o       = r_q.irq;
    assign link_req_o  = r_q.link_req;
    assign src_addr_o  = r_q.src;
    assign dst_addr_o  = r_q.dst;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    p_irq_with_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (done_o && error_o));

    p_link_req_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        link_req_o |-> (done_o && !busy_o));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(cont_link_i) && r_q.self_link) |-> (busy_o && !mem_we_o));
endmodule

// File: tb/dma_minor_loop_engine_test.sv
module dma_minor_loop_engine_test;
    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] nb;
        logic [15:0] sinc;
        logic [15:0] dinc;
        logic [19:0] off;
        logic        map;
        logic        so;
        logic        doe;
    } vec_t;

    // src, dst, nbytes, sinc, dinc, offset, map, src_off_en, dst_off_en
    localparam vec_t VEC [5] = '{
        '{32'h0000_1000, 32'h0000_2000, 32'd16,          16'd4,      16'd4, 20'h00000,   1'b0, 1'b0, 1'b0},
        '{32'h0000_5000, 32'h0000_6000, 32'd9,           16'hFFFC,   16'd8, 20'hFFFF0,   1'b1, 1'b1, 1'b0},
        '{32'h0000_7000, 32'h0000_8000, 32'h0000_0408,   16'd4,      16'd4, 20'h00040,   1'b1, 1'b0, 1'b1},
        '{32'h0001_0000, 32'h0002_0000, 32'h0000_0408,   16'd4,      16'd4, 20'h00040,   1'b1, 1'b0, 1'b0},
        '{32'h0000_9000, 32'h0000_A000, 32'd0,           16'd4,      16'd4, 20'h00100,   1'b0, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] src_addr_i = '0, dst_addr_i = '0, nbytes_i = '0;
    logic [15:0] src_inc_i = '0, dst_inc_i = '0;
    logic [19:0] loop_off_i = '0;
    logic        map_en_i = 1'b0, src_off_en_i = 1'b0, dst_off_en_i = 1'b0;
    logic        self_link_i = 1'b0, cont_link_i = 1'b0, err_irq_en_i = 1'b0;
    logic        cancel_i = 1'b0, err_cancel_i = 1'b0;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o, error_o, irq_o, link_req_o;
    logic [31:0] src_addr_o, dst_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    dma_minor_loop_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .nbytes_i(nbytes_i),
        .src_inc_i(src_inc_i), .dst_inc_i(dst_inc_i), .loop_off_i(loop_off_i),
        .map_en_i(map_en_i), .src_off_en_i(src_off_en_i), .dst_off_en_i(dst_off_en_i),
        .self_link_i(self_link_i), .cont_link_i(cont_link_i), .err_irq_en_i(err_irq_en_i),
        .cancel_i(cancel_i), .err_cancel_i(err_cancel_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .irq_o(irq_o),
        .link_req_o(link_req_o), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    // Memory responder: acknowledges one cycle after each request, logs beats.
    logic        ack_r = 1'b0;
    int          beat_cnt = 0;
    logic [31:0] rd_log [64];
    logic [31:0] wr_log [64];
    logic [31:0] wd_log [64];
    logic [31:0] last_rd = '0;

    assign mem_ack_i   = ack_r;
    assign mem_rdata_i = pat(mem_addr_o);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        ack_r <= mem_req_o && !ack_r;
        if (mem_req_o && !ack_r) begin
            if (!mem_we_o) begin
                last_rd <= mem_addr_o;
                if (beat_cnt < 64) rd_log[beat_cnt] <= mem_addr_o;
            end else begin
                if (beat_cnt < 64) begin
                    wr_log[beat_cnt] <= mem_addr_o;
                    wd_log[beat_cnt] <= mem_wdata_o;
                end
                beat_cnt <= beat_cnt + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_desc(input vec_t v, input logic self, input logic irqen);
        src_addr_i = v.src; dst_addr_i = v.dst; nbytes_i = v.nb;
        src_inc_i = v.sinc; dst_inc_i = v.dinc; loop_off_i = v.off;
        map_en_i = v.map; src_off_en_i = v.so; dst_off_en_i = v.doe;
        self_link_i = self; err_irq_en_i = irqen;
    endtask

    task automatic kick();
        @(negedge clk);
        beat_cnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done_o) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) chk(1'b0, "watchdog done", 32'h0, 32'h1);
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] x);
        return {{16{x[15]}}, x};
    endfunction
    function automatic logic [31:0] sx20(input logic [19:0] x);
        return {{12{x[19]}}, x};
    endfunction

    function automatic int eff_beats(input vec_t v);
        logic [31:0] n;
        n = (v.map && (v.so || v.doe)) ? {22'd0, v.nb[9:0]} : v.nb;
        return (n == 0) ? 1 : int'((n + 32'd3) >> 2);
    endfunction

    task automatic check_trace(input vec_t v, input int beats, input string req);
        logic ok = 1'b1;
        int   lim = (beats < 64) ? beats : 64;
        for (int i = 0; i < lim; i++) begin
            if (rd_log[i] != v.src + 32'(i) * sx16(v.sinc)) ok = 1'b0;
            if (wr_log[i] != v.dst + 32'(i) * sx16(v.dinc)) ok = 1'b0;
            if (wd_log[i] != pat(rd_log[i])) ok = 1'b0;
        end
        chk(ok, req, rd_log[0], v.src);
    endtask

    task automatic check_retire(input vec_t v, input int beats, input logic cxl, input string req);
        logic [31:0] es, ed;
        es = v.src + 32'(beats) * sx16(v.sinc) + ((v.map && v.so) ? sx20(v.off) : 32'h0);
        ed = v.dst + 32'(beats) * sx16(v.dinc) + ((v.map && v.doe) ? sx20(v.off) : 32'h0);
        chk(beat_cnt == beats, {req, " beats"}, 32'(beat_cnt), 32'(beats));
        chk(src_addr_o == es, {req, " src"}, src_addr_o, es);
        chk(dst_addr_o == ed, {req, " dst"}, dst_addr_o, ed);
        if (!cxl) check_trace(v, beats, {req, " trace R2"});
    endtask

    initial begin : main
        logic ok;
        vec_t v;
        int   nb;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({busy_o, mem_req_o, done_o, error_o, irq_o, link_req_o} == 6'b0,
            "R1 reset outputs", {26'd0, busy_o, mem_req_o, done_o, error_o, irq_o, link_req_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_o, "R1 idle after reset", {31'd0, busy_o}, 32'h0);

        // Table walk: R2 R3 R4 R5
        for (int k = 0; k < 5; k++) begin
            v = VEC[k];
            set_desc(v, 1'b0, 1'b0);
            kick();
            wait_done(ok);
            nb = eff_beats(v);
            check_retire(v, nb, 1'b0, $sformatf("R3 R4 R5 vec%0d", k));
            chk(!error_o && !irq_o, "R3 no error on normal end", {31'd0, error_o}, 32'h0);
            @(negedge clk);
            chk(!done_o && !busy_o, "R3 done single cycle", {31'd0, done_o}, 32'h0);
        end

        // R6: cancel during first read; the pair's write still finishes
        v = '{32'h0000_B000, 32'h0000_C000, 32'd64, 16'd4, 16'd4, 20'h00020, 1'b1, 1'b1, 1'b1};
        set_desc(v, 1'b0, 1'b1);
        kick();
        chk(mem_req_o && !mem_we_o, "R6 first read pending", {31'd0, mem_we_o}, 32'h0);
        cancel_i = 1'b1;
        @(negedge clk);
        cancel_i = 1'b0;
        wait_done(ok);
        check_retire(v, 1, 1'b1, "R6 cancel");
        chk(wd_log[0] == pat(v.src), "R6 pair write completed", wd_log[0], pat(v.src));
        chk(!error_o && !irq_o, "R6 cancel is not an error", {31'd0, error_o}, 32'h0);
        // R6: pending cancel is gone for the next loop
        v.nb = 32'd12;
        set_desc(v, 1'b0, 1'b0);
        kick();
        wait_done(ok);
        chk(beat_cnt == 3, "R6 cancel self-cleared", 32'(beat_cnt), 32'd3);

        // R7: error-cancel during a write, interrupt enabled
        v = '{32'h0000_D000, 32'h0000_E000, 32'd64, 16'd4, 16'd4, 20'h00000, 1'b0, 1'b0, 1'b0};
        set_desc(v, 1'b0, 1'b1);
        kick();
        while (!(mem_req_o && mem_we_o)) @(negedge clk);
        err_cancel_i = 1'b1;
        @(negedge clk);
        err_cancel_i = 1'b0;
        wait_done(ok);
        check_retire(v, 1, 1'b1, "R7 err-cancel");
        chk(error_o && irq_o, "R7 error and irq at done", {30'd0, error_o, irq_o}, 32'h3);
        @(negedge clk);
        chk(error_o && !irq_o, "R7 error holds, irq pulse", {30'd0, error_o, irq_o}, 32'h2);

        // R8: both strobes together, irq disabled; start also clears error (R7)
        set_desc(v, 1'b0, 1'b0);
        kick();
        chk(!error_o, "R7 error cleared by start", {31'd0, error_o}, 32'h0);
        cancel_i = 1'b1; err_cancel_i = 1'b1;
        @(negedge clk);
        cancel_i = 1'b0; err_cancel_i = 1'b0;
        wait_done(ok);
        chk(error_o && !irq_o, "R8 error-cancel wins", {30'd0, error_o, irq_o}, 32'h2);
        chk(beat_cnt == 1, "R8 stopped at pair", 32'(beat_cnt), 32'd1);

        // R9: strobes while idle are dropped
        @(negedge clk);
        cancel_i = 1'b1; err_cancel_i = 1'b1;
        @(negedge clk);
        cancel_i = 1'b0; err_cancel_i = 1'b0;
        repeat (2) @(negedge clk);
        v.nb = 32'd12;
        set_desc(v, 1'b0, 1'b0);
        kick();
        wait_done(ok);
        chk(beat_cnt == 3, "R9 idle cancel ignored", 32'(beat_cnt), 32'd3);
        chk(!error_o, "R9 no error", {31'd0, error_o}, 32'h0);

        // R12: start while busy ignored
        v = '{32'h0001_1000, 32'h0001_2000, 32'd16, 16'd4, 16'd4, 20'h00000, 1'b0, 1'b0, 1'b0};
        set_desc(v, 1'b0, 1'b0);
        kick();
        @(negedge clk);
        src_addr_i = 32'h00FF_0000; nbytes_i = 32'd4;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(ok);
        check_retire(v, 4, 1'b0, "R12 busy start");

        // R10 / R11: continuous self-link restart, then drop continuous mode
        v = '{32'h0000_3000, 32'h0000_4000, 32'd8, 16'd4, 16'd4, 20'h00100, 1'b1, 1'b1, 1'b1};
        set_desc(v, 1'b1, 1'b0);
        cont_link_i = 1'b1;
        kick();
        wait_done(ok);
        chk(busy_o && !link_req_o, "R10 stays busy", {30'd0, busy_o, link_req_o}, 32'h2);
        chk(src_addr_o == 32'h0000_3108, "R10 offset applied", src_addr_o, 32'h0000_3108);
        cont_link_i = 1'b0;
        @(negedge clk);
        wait_done(ok);
        chk(rd_log[2] == 32'h0000_3108, "R10 restart read addr", rd_log[2], 32'h0000_3108);
        chk(beat_cnt == 4, "R10 full second loop", 32'(beat_cnt), 32'd4);
        chk(link_req_o && !busy_o, "R11 link request", {30'd0, link_req_o, busy_o}, 32'h2);
        chk(src_addr_o == 32'h0000_3210, "R11 second src", src_addr_o, 32'h0000_3210);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        wait (cyc > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule